// File: doc/BRIEF.md
# Byte-Lane Mask and Aligner

This block is the combinational datapath between a load/store port and a memory that is one word wide. It takes an access length in bytes and the full byte address. From the length and the byte offset inside the word it forms a unary byte-enable run. The run is placed in a mask wider than the word, so an access that crosses the end of the word shows up as set bits above the top lane. From the same run it forms a bit-level mask.

For loads, it masks the word read from memory down to the requested bytes. It then shifts the result so the first requested byte sits in lane 0. For stores, it moves the store data up into the addressed lanes. It also gives the low part of the byte mask as per-lane write enables and the word-aligned address.

The block has no registers and no handshake. Splitting a misaligned access into two is left to the requester, which uses the misalign flag.

Top module: `byte_lane_aligner`

## Requirements
- R1: `byte_en_o` bit i is 1 exactly when offset <= i < offset + length. Here offset = `addr_i[OFF_W-1:0]` and length = `len_i`. The mask is WORD_BYTES + 2^LEN_W - 1 bits wide, which is 23 bits by default.
- R2: A length of 0 gives an all-zero `byte_en_o`, `misalign_o` = 0, `wr_en_o` = 0 and `bit_mask_o` = 0.
- R3: `misalign_o` is 1 exactly when offset + length > WORD_BYTES, that is, when some `byte_en_o` bit at position WORD_BYTES or above is set.
- R4: `bit_mask_o[8k+7:8k]` is all ones when `byte_en_o[k]` is 1 and all zeros when it is 0, for every lane k below WORD_BYTES.
- R5: `ld_data_o` is (`rd_word_i` AND `bit_mask_o`) shifted right by 8 × offset bits, with zeros filling from the top.
- R6: `wr_data_o` is `st_data_i` shifted left by 8 × offset bits. Bytes that move past the top of the word are dropped, and the lanes below the offset are zero.
- R7: `wr_en_o` equals the low WORD_BYTES bits of `byte_en_o`, one enable per byte lane, with lane 0 as bit 0.
- R8: `word_addr_o` equals `addr_i` with its low OFF_W bits removed, so it is `addr_i` shifted right by OFF_W.
- R9: Every output is a function of the present inputs only. A new input value shows at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| len_i | input | LEN_W (4) | Access length in bytes |
| addr_i | input | ADDR_W (48) | Byte address; the low OFF_W bits are the lane offset |
| rd_word_i | input | DATA_W (64) | Word read from memory |
| st_data_i | input | DATA_W (64) | Store data, right-justified in lane 0 |
| byte_en_o | output | MASK_W (23) | Unary byte mask shifted by the offset |
| bit_mask_o | output | DATA_W (64) | Byte mask expanded to bits over the word |
| misalign_o | output | 1 | Access runs past the end of the word |
| wr_en_o | output | WORD_BYTES (8) | Per-lane write enables |
| word_addr_o | output | ADDR_W-OFF_W (45) | Word-aligned address |
| ld_data_o | output | DATA_W (64) | Masked load data, shifted down to lane 0 |
| wr_data_o | output | DATA_W (64) | Store data shifted up into its lanes |

## Verification
The bench uses the default parameters: an 8-byte word, a 4-bit length and a 48-bit address. With these values the whole length/offset space is only 128 pairs. The bench sweeps every pair, each under three different data and address patterns. This covers the zero length, every exact fit against the word end, and every overrun up to 22 bits of mask. Expected lane contents are built byte by byte in the bench.

// File: rtl/byte_lane_pkg.sv
package byte_lane_pkg;
    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
    parameter int unsigned WORD_BYTES = 8,
    parameter int unsigned LEN_W      = 4,
    localparam int unsigned OFF_W     = $clog2(WORD_BYTES),
    localparam int unsigned MASK_W    = WORD_BYTES + (1 << LEN_W) - 1
) (
    input  logic [LEN_W-1:0]  len_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [MASK_W-1:0] mask_o,
    output logic              over_o
);
    logic [MASK_W-1:0] run_d;

    always_comb begin
        run_d = '0;
        for (int i = 0; i < MASK_W; i++) begin
            run_d[i] = (i < int'(len_i));
        end
        mask_o = run_d << off_i;
        over_o = |mask_o[MASK_W-1:WORD_BYTES];
    end

    // R1: the run holds exactly len ones
    always_comb begin
        a_r1_run_count: assert ($countones(mask_o) == int'(len_i))
            else $error("R1 mask ones count mismatch");
    end
endmodule

// File: rtl/lane_bit_expand.sv
module lane_bit_expand
    import byte_lane_pkg::*;
#(
    parameter int unsigned WORD_BYTES = 8,
    localparam int unsigned DATA_W    = WORD_BYTES * BYTE_W
) (
    input  logic [WORD_BYTES-1:0] lane_i,
    output logic [DATA_W-1:0]     bits_o
);
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        assign bits_o[k*BYTE_W +: BYTE_W] = {BYTE_W{lane_i[k]}};
    end

    // R4: bit population tracks lane population
    always_comb begin
        a_r4_bit_pop: assert ($countones(bits_o) == BYTE_W * $countones(lane_i))
            else $error("R4 bit mask population mismatch");
    end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
    import byte_lane_pkg::*;
#(
    parameter int unsigned WORD_BYTES = 8,
    localparam int unsigned OFF_W     = $clog2(WORD_BYTES),
    localparam int unsigned DATA_W    = WORD_BYTES * BYTE_W
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] rd_word_i,
    input  logic [DATA_W-1:0] bit_mask_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic [DATA_W-1:0] ld_data_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int unsigned SH_W = OFF_W + $clog2(BYTE_W);

    logic [SH_W-1:0]   shamt_d;
    logic [DATA_W-1:0] kept_d;

    always_comb begin
        shamt_d   = {off_i, {($clog2(BYTE_W)){1'b0}}};
        kept_d    = rd_word_i & bit_mask_i;
        ld_data_o = kept_d >> shamt_d;
        wr_data_o = st_data_i << shamt_d;
    end

    // R6: lanes below the offset carry no store data
    always_comb begin
        a_r6_low_lanes_zero: assert ((off_i == '0) || (wr_data_o[0 +: BYTE_W] == '0))
            else $error("R6 lane 0 not cleared");
    end
endmodule

// File: rtl/byte_lane_aligner.sv
module byte_lane_aligner
    import byte_lane_pkg::*;
#(
    parameter int unsigned WORD_BYTES = 8,
    parameter int unsigned LEN_W      = 4,
    parameter int unsigned ADDR_W     = 48,
    localparam int unsigned OFF_W     = $clog2(WORD_BYTES),
    localparam int unsigned DATA_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned MASK_W    = WORD_BYTES + (1 << LEN_W) - 1
) (
    input  logic [LEN_W-1:0]        len_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       rd_word_i,
    input  logic [DATA_W-1:0]       st_data_i,
    output logic [MASK_W-1:0]       byte_en_o,
    output logic [DATA_W-1:0]       bit_mask_o,
    output logic                    misalign_o,
    output logic [WORD_BYTES-1:0]   wr_en_o,
    output logic [ADDR_W-OFF_W-1:0] word_addr_o,
    output logic [DATA_W-1:0]       ld_data_o,
    output logic [DATA_W-1:0]       wr_data_o
);
    logic [OFF_W-1:0] off_d;

    always_comb begin
        off_d       = addr_i[OFF_W-1:0];
        word_addr_o = addr_i[ADDR_W-1:OFF_W];
        wr_en_o     = byte_en_o[WORD_BYTES-1:0];
    end

    lane_mask_gen #(
        .WORD_BYTES(WORD_BYTES),
        .LEN_W     (LEN_W)
    ) u_mask (
        .len_i (len_i),
        .off_i (off_d),
        .mask_o(byte_en_o),
        .over_o(misalign_o)
    );

    lane_bit_expand #(
        .WORD_BYTES(WORD_BYTES)
    ) u_expand (
        .lane_i(wr_en_o),
        .bits_o(bit_mask_o)
    );

    lane_shifter #(
        .WORD_BYTES(WORD_BYTES)
    ) u_shift (
        .off_i     (off_d),
        .rd_word_i (rd_word_i),
        .bit_mask_i(bit_mask_o),
        .st_data_i (st_data_i),
        .ld_data_o (ld_data_o),
        .wr_data_o (wr_data_o)
    );

    always_comb begin
        a_r2_zero_len: assert ((len_i != '0) || ((byte_en_o == '0) && !misalign_o))
            else $error("R2 zero length produced lanes");
        a_r3_overrun: assert (misalign_o == ((int'(off_d) + int'(len_i)) > int'(WORD_BYTES)))
            else $error("R3 misalign flag mismatch");
        a_r7_enable_bound: assert ($countones(wr_en_o) <= int'(len_i))
            else $error("R7 too many write enables");
        a_r5_load_width: assert ((ld_data_o & ~(bit_mask_o >> {off_d, 3'b000})) == '0)
            else $error("R5 load data outside requested bytes");
    end
endmodule

// File: tb/sim_byte_lane_aligner.sv
module sim_byte_lane_aligner;
    logic        clk = 1'b0;
    logic [3:0]  len;
    logic [47:0] addr;
    logic [63:0] rd, st;
    logic [22:0] byte_en;
    logic [63:0] bit_mask, ld_data, wr_data;
    logic        misalign;
    logic [7:0]  wr_en;
    logic [44:0] word_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    byte_lane_aligner u0 (
        .len_i      (len),
        .addr_i     (addr),
        .rd_word_i  (rd),
        .st_data_i  (st),
        .byte_en_o  (byte_en),
        .bit_mask_o (bit_mask),
        .misalign_o (misalign),
        .wr_en_o    (wr_en),
        .word_addr_o(word_addr),
        .ld_data_o  (ld_data),
        .wr_data_o  (wr_data)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (len=%0d addr=%h)",
                     req, act, exp, len, addr);
        end
    endtask

    function automatic logic [63:0] pat(input int k);
        logic [63:0] v = 64'h9E37_79B9_7F4A_7C15 * (64'(k) + 64'd3);
        return v ^ {v[31:0], v[63:32]} ^ 64'hA5C3_0F96_1E2D_4B78;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] m64, exp_bits, exp_ld, exp_wr;
        logic [22:0] exp_mask;
        int          off;

        // R2: zero length at start, all-zero mask state
        len = '0; addr = '0; rd = '1; st = '1;
        #1;
        check(byte_en == '0 && !misalign, "R2", {40'd0, byte_en}, 64'd0);
        check(wr_en == '0 && bit_mask == '0, "R2", bit_mask, 64'd0);
        check(ld_data == '0, "R5", ld_data, 64'd0);

        for (int p = 0; p < 3; p++) begin
            for (int l = 0; l < 16; l++) begin
                for (int o = 0; o < 8; o++) begin
                    @(negedge clk);
                    len  = 4'(l);
                    addr = {pat(p * 200 + l * 8 + o)[44:0], 3'(o)};
                    rd   = pat(p * 300 + l + 1000);
                    st   = pat(p * 500 + o + 2000);
                    #1;
                    off      = o;
                    m64      = ((64'd1 << l) - 64'd1) << o;
                    exp_mask = m64[22:0];
                    exp_bits = '0;
                    exp_ld   = '0;
                    exp_wr   = '0;
                    for (int j = 0; j < 8; j++) begin
                        if (j >= off && j < off + l) exp_bits[j*8 +: 8] = 8'hFF;
                        if (j < l && off + j < 8) exp_ld[j*8 +: 8] = rd[(off + j)*8 +: 8];
                        if (j >= off) exp_wr[j*8 +: 8] = st[(j - off)*8 +: 8];
                    end
                    check(byte_en == exp_mask, "R1", {41'd0, byte_en}, {41'd0, exp_mask});
                    check(misalign == ((o + l) > 8), "R3", {63'd0, misalign}, {63'd0, 1'((o + l) > 8)});
                    check(bit_mask == exp_bits, "R4", bit_mask, exp_bits);
                    check(ld_data == exp_ld, "R5", ld_data, exp_ld);
                    check(wr_data == exp_wr, "R6", wr_data, exp_wr);
                    check(wr_en == exp_mask[7:0], "R7", {56'd0, wr_en}, {56'd0, exp_mask[7:0]});
                    check(word_addr == addr[47:3], "R8", {19'd0, word_addr}, {19'd0, addr[47:3]});
                    if (l == 0)
                        check(byte_en == '0 && !misalign && wr_en == '0, "R2",
                              {41'd0, byte_en}, 64'd0);
                end
            end
        end

        // R9: change inputs with no clock edge in between
        @(negedge clk);
        len = 4'd2; addr = 48'h5;
        #1;
        check(byte_en == 23'h60, "R9", {41'd0, byte_en}, 64'h60);
        len = 4'd4; addr = 48'h6;
        #1;
        check(byte_en == 23'h3C0 && misalign, "R9", {41'd0, byte_en}, 64'h3C0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule